// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Timer Register Bank

This block lets an 8-bit processor bus reach the wide registers of a 16-bit timer: the counter, two compare registers and a capture register. All of them share one byte-wide staging register. A write to a high-byte address lands only in the staging register. The following low-byte write commits the staged byte and the new low byte to the target in a single clock edge.

Reads work the other way round. A low-byte read returns the live low byte and, in the same cycle, copies that register's high byte into the staging register. A later high-byte read therefore returns a byte from the same instant, even if the counter has moved on since.

Around this access path sit a free-running counter advanced by an external tick, equality compare on both compare channels, and an edge-triggered capture whose source is either a pin or a comparator output. Four event flags are gated by an interrupt mask and a global enable to form interrupt requests.

Top module: `tmr16_regbank`

## Requirements
- R1: After reset, the counter, the compare and capture registers, the staging register, the mask, the flags, `irq_req` and `t0_ien` are all zero.
- R2: Each cycle with `tick` high increments the counter by one. A tick at 0xFFFF wraps the counter to 0 and sets the overflow flag (flag byte bit 3). A bus write to the counter takes precedence over a tick in the same cycle.
- R3: A write to a high-byte address (0x1F compare A, 0x1D compare B, 0x1B capture, 0x2D counter) changes only the staging register. A write to the matching low-byte address (0x1E, 0x1C, 0x1A, 0x2C) loads {staging, data} into the register in one edge.
- R4: A read of a low-byte address returns the register's low byte and copies its high byte into the staging register at that edge. A read of any high-byte address returns the staging register.
- R5: A single staging register serves every 16-bit register: a byte staged by a write to one register's high address is committed by a low-byte write to any other register.
- R6: On a tick while the counter equals compare A, flag bit 4 is set; on a tick while it equals compare B, flag bit 5 is set.
- R7: The capture source passes through a two-flop synchronizer and an edge detector. On the third rising clock edge after the source changes, the capture register loads the counter and flag bit 7 is set. A capture event overrides a bus write to the capture register in the same cycle.
- R8: With `cap_on_rise` = 1, only rising source edges capture; with 0, only falling edges capture. The other edge changes neither the capture register nor the flag.
- R9: With `cap_from_acmp` = 0 the source is `cap_pin`; with 1 it is `acmp_out`. The unselected input has no effect.
- R10: The mask register at 0x26 has these bits: bit 7 capture, bit 5 compare B, bit 4 compare A, bit 3 overflow. Bits 2..0 belong to the second timer and appear on `t0_ien[2:0]`. Bit 6 always reads 0.
- R11: `irq_req[3]` (capture), `[2]` (compare B), `[1]` (compare A) and `[0]` (overflow) are each high exactly when their flag is set, their mask bit is one, and `gie` is high.
- R12: The flag byte at 0x25 uses the mask bit positions. Writing a one clears that flag, and writing a zero has no effect. A hardware set in the same cycle wins over the clear.
- R13: `irq_ack[i]` clears the flag behind `irq_req[i]` at the next edge, unless the same flag is set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effect on low-byte addresses) |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| tick | input | 1 | Counter advance enable |
| cap_pin | input | 1 | Capture pin |
| acmp_out | input | 1 | Analog comparator output |
| cap_from_acmp | input | 1 | Capture source select |
| cap_on_rise | input | 1 | Capture edge polarity |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Per-source interrupt acknowledge |
| irq_req | output | 4 | Per-source interrupt request |
| t0_ien | output | 3 | Second-timer enable bits from the mask |

## Verification
Read data is combinational from the address, so the bench samples `bus_rdata` one nanosecond after driving a read at the falling edge, before the rising edge whose side effect (the staging copy) it tests next. Writes, compare hits, the overflow flag and acknowledges take effect on the rising edge after they are driven. Each check is therefore made at the next falling edge, or by a bus read issued after it. A capture lands on the third rising edge after the source changes. The bench drives the pin at a falling edge and checks `irq_req` at each of the next three falling edges: low, low, then high. For the atomic-read check, the counter keeps ticking between the low and high reads, which would expose a high byte taken late.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   localparam int NSRC = 4;

   typedef enum logic [1:0] {
      SRC_OVF  = 2'd0,
      SRC_CMPA = 2'd1,
      SRC_CMPB = 2'd2,
      SRC_CAP  = 2'd3
   } src_e;

   localparam logic [5:0] A_CAP_LO  = 6'h1A;
   localparam logic [5:0] A_CAP_HI  = 6'h1B;
   localparam logic [5:0] A_CMPB_LO = 6'h1C;
   localparam logic [5:0] A_CMPB_HI = 6'h1D;
   localparam logic [5:0] A_CMPA_LO = 6'h1E;
   localparam logic [5:0] A_CMPA_HI = 6'h1F;
   localparam logic [5:0] A_FLAG    = 6'h25;
   localparam logic [5:0] A_MASK    = 6'h26;
   localparam logic [5:0] A_CNT_LO  = 6'h2C;
   localparam logic [5:0] A_CNT_HI  = 6'h2D;

   // Source vector -> byte layout shared by mask and flag registers.
   function automatic logic [7:0] src_to_byte(input logic [NSRC-1:0] v);
      return {v[SRC_CAP], 1'b0, v[SRC_CMPB], v[SRC_CMPA], v[SRC_OVF], 3'b000};
   endfunction

   function automatic logic [NSRC-1:0] byte_to_src(input logic [7:0] b);
      logic [NSRC-1:0] v;
      v[SRC_CAP]  = b[7];
      v[SRC_CMPB] = b[5];
      v[SRC_CMPA] = b[4];
      v[SRC_OVF]  = b[3];
      return v;
   endfunction

endpackage

// File: rtl/tmr16_count.sv
module tmr16_count #(
   parameter int CNT_W = 16,
   parameter int NCMP  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_i,
   input  logic                        ld_i,
   input  logic [NCMP-1:0]             cmp_we_i,
   input  logic [CNT_W-1:0]            wval_i,
   output logic [CNT_W-1:0]            cnt_o,
   output logic [NCMP-1:0][CNT_W-1:0]  cmp_o,
   output logic [NCMP-1:0]             hit_o,
   output logic                        ovf_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   assign adv = tick_i & ~ld_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_i)  cnt_q <= wval_i;
      else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
   end

   assign cnt_o = cnt_q;
   assign ovf_o = adv & (cnt_q == CNT_MAX);

   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cmp_q <= '0;
         else if (cmp_we_i[g]) cmp_q <= wval_i;
      end

      assign cmp_o[g] = cmp_q;
      assign hit_o[g] = adv & (cnt_q == cmp_q);
   end

   // R2: counting step and wrap
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_i) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             acmp_i,
   input  logic             sel_acmp_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wval_i,
   output logic [CNT_W-1:0] cap_o,
   output logic             evt_o
);

   logic                   src;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   s_now;
   logic [CNT_W-1:0]       cap_q;

   assign src = sel_acmp_i ? acmp_i : pin_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], src};
   end

   assign s_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= s_now;
   end

   assign evt_o = rise_i ? (s_now & ~last_q) : (~s_now & last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_q <= '0;
      else if (evt_o) cap_q <= cnt_i;
      else if (wr_i)  cap_q <= wval_i;
   end

   assign cap_o = cap_q;

   // R7: an event snapshots the counter, overriding a bus write
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> (cap_q == $past(cnt_i)));
   // R8: only one polarity can be seen per cycle
   p_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o && rise_i) |-> (s_now && !last_q));

endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic [NSRC-1:0] ack_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic            gie_i,
   output logic [NSRC-1:0] flag_o,
   output logic [NSRC-1:0] req_o
);

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (set_i[k]) flag_q <= 1'b1;
         else if (clr_i[k] || ack_i[k]) flag_q <= 1'b0;
      end

      assign flag_o[k] = flag_q;
      assign req_o[k]  = flag_q & mask_i[k] & gie_i;

      // R12: hardware set beats a same-cycle clear
      p_setwins_r12: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> flag_q);
      // R13: acknowledge or write-one clears when no set collides
      p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
         ((ack_i[k] || clr_i[k]) && !set_i[k]) |=> !flag_q);
      p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q && !ack_i[k] && !clr_i[k]) |=> flag_q);
   end

endmodule

// File: rtl/tmr16_regbank.sv
module tmr16_regbank
   import tmr16_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick,
   input  logic              cap_pin,
   input  logic              acmp_out,
   input  logic              cap_from_acmp,
   input  logic              cap_on_rise,
   input  logic              gie,
   input  logic [3:0]        irq_ack,
   output logic [3:0]        irq_req,
   output logic [2:0]        t0_ien
);

   localparam int CNT_W = 2 * DATA_W;
   localparam int NCMP  = 2;

   localparam logic [ADDR_W-1:0] AD_CAP_LO  = ADDR_W'(A_CAP_LO);
   localparam logic [ADDR_W-1:0] AD_CAP_HI  = ADDR_W'(A_CAP_HI);
   localparam logic [ADDR_W-1:0] AD_CMPB_LO = ADDR_W'(A_CMPB_LO);
   localparam logic [ADDR_W-1:0] AD_CMPB_HI = ADDR_W'(A_CMPB_HI);
   localparam logic [ADDR_W-1:0] AD_CMPA_LO = ADDR_W'(A_CMPA_LO);
   localparam logic [ADDR_W-1:0] AD_CMPA_HI = ADDR_W'(A_CMPA_HI);
   localparam logic [ADDR_W-1:0] AD_FLAG    = ADDR_W'(A_FLAG);
   localparam logic [ADDR_W-1:0] AD_MASK    = ADDR_W'(A_MASK);
   localparam logic [ADDR_W-1:0] AD_CNT_LO  = ADDR_W'(A_CNT_LO);
   localparam logic [ADDR_W-1:0] AD_CNT_HI  = ADDR_W'(A_CNT_HI);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("tmr16_regbank: DATA_W must be at least 8");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("tmr16_regbank: ADDR_W must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr16_regbank: SYNC_STAGES must be at least 2");
   end

   logic [DATA_W-1:0]              temp_q;
   logic [CNT_W-1:0]               commit_val;
   logic [CNT_W-1:0]               cnt;
   logic [CNT_W-1:0]               cap_val;
   logic [NCMP-1:0][CNT_W-1:0]     cmp_val;
   logic [NCMP-1:0]                cmp_we;
   logic [NCMP-1:0]                cmp_hit;
   logic                           cnt_ld;
   logic                           cap_we;
   logic                           ovf;
   logic                           cap_evt;
   logic                           rd;
   logic                           hi_sel;
   logic                           lo_rd;
   logic [DATA_W-1:0]              hi_src;
   logic [7:0]                     mask_q;
   logic [NSRC-1:0]                flags;
   logic [NSRC-1:0]                set_v;
   logic [NSRC-1:0]                clr_v;
   logic [NSRC-1:0]                mask_v;

   assign rd         = bus_re & ~bus_we;
   assign commit_val = {temp_q, bus_wdata};

   // ---------------- write decode ----------------
   always_comb begin
      cmp_we[0] = bus_we && (bus_addr == AD_CMPA_LO);
      cmp_we[1] = bus_we && (bus_addr == AD_CMPB_LO);
      cnt_ld    = bus_we && (bus_addr == AD_CNT_LO);
      cap_we    = bus_we && (bus_addr == AD_CAP_LO);
      hi_sel    = (bus_addr == AD_CMPA_HI) || (bus_addr == AD_CMPB_HI) ||
                  (bus_addr == AD_CAP_HI)  || (bus_addr == AD_CNT_HI);
   end

   // ---------------- staging register ----------------
   always_comb begin
      lo_rd  = 1'b0;
      hi_src = '0;
      if (rd) begin
         case (bus_addr)
            AD_CMPA_LO: begin lo_rd = 1'b1; hi_src = cmp_val[0][CNT_W-1:DATA_W]; end
            AD_CMPB_LO: begin lo_rd = 1'b1; hi_src = cmp_val[1][CNT_W-1:DATA_W]; end
            AD_CAP_LO:  begin lo_rd = 1'b1; hi_src = cap_val[CNT_W-1:DATA_W];    end
            AD_CNT_LO:  begin lo_rd = 1'b1; hi_src = cnt[CNT_W-1:DATA_W];        end
            default:    begin lo_rd = 1'b0; hi_src = '0;                         end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                temp_q <= '0;
      else if (bus_we && hi_sel) temp_q <= bus_wdata;
      else if (lo_rd)            temp_q <= hi_src;
   end

   // ---------------- mask and flag clear ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mask_q <= '0;
      else if (bus_we && bus_addr == AD_MASK)  mask_q <= bus_wdata[7:0] & 8'hBF;
   end

   assign mask_v = byte_to_src(mask_q);
   assign t0_ien = mask_q[2:0];
   assign clr_v  = (bus_we && bus_addr == AD_FLAG) ? byte_to_src(bus_wdata[7:0]) : '0;

   always_comb begin
      set_v           = '0;
      set_v[SRC_OVF]  = ovf;
      set_v[SRC_CMPA] = cmp_hit[0];
      set_v[SRC_CMPB] = cmp_hit[1];
      set_v[SRC_CAP]  = cap_evt;
   end

   // ---------------- read mux ----------------
   always_comb begin
      case (bus_addr)
         AD_CMPA_HI, AD_CMPB_HI, AD_CAP_HI, AD_CNT_HI: bus_rdata = temp_q;
         AD_CMPA_LO: bus_rdata = cmp_val[0][DATA_W-1:0];
         AD_CMPB_LO: bus_rdata = cmp_val[1][DATA_W-1:0];
         AD_CAP_LO:  bus_rdata = cap_val[DATA_W-1:0];
         AD_CNT_LO:  bus_rdata = cnt[DATA_W-1:0];
         AD_MASK:    bus_rdata = DATA_W'(mask_q);
         AD_FLAG:    bus_rdata = DATA_W'(src_to_byte(flags));
         default:    bus_rdata = '0;
      endcase
   end

   // ---------------- sub-blocks ----------------
   tmr16_count #(.CNT_W(CNT_W), .NCMP(NCMP)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .ld_i     (cnt_ld),
      .cmp_we_i (cmp_we),
      .wval_i   (commit_val),
      .cnt_o    (cnt),
      .cmp_o    (cmp_val),
      .hit_o    (cmp_hit),
      .ovf_o    (ovf)
   );

   tmr16_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (cap_pin),
      .acmp_i     (acmp_out),
      .sel_acmp_i (cap_from_acmp),
      .rise_i     (cap_on_rise),
      .cnt_i      (cnt),
      .wr_i       (cap_we),
      .wval_i     (commit_val),
      .cap_o      (cap_val),
      .evt_o      (cap_evt)
   );

   tmr16_irq #(.NSRC(NSRC)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .ack_i  (irq_ack),
      .mask_i (mask_v),
      .gie_i  (gie),
      .flag_o (flags),
      .req_o  (irq_req)
   );

   // R3: staging a high byte leaves the target untouched
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AD_CMPA_HI) |=> $stable(cmp_val[0]));
   // R4: low-byte read snapshots the counter high byte
   p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == AD_CNT_LO) |=> (temp_q == $past(cnt[CNT_W-1:DATA_W])));
   // R10: reserved mask bit never reads as one
   p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AD_MASK) |-> (bus_rdata[6] == 1'b0));
   // R11: no request without the global enable
   p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req != '0) |-> gie);

endmodule

// File: tb/tmr16_regbank_bench.sv
`timescale 1ns/1ps
module tmr16_regbank_bench;

   localparam real T_CLK = 4.0;
   localparam int  NVEC  = 27;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0] bus_rdata;
   logic       tick = 1'b0, cap_pin = 1'b0, acmp_out = 1'b0;
   logic       cap_from_acmp = 1'b0, cap_on_rise = 1'b1, gie = 1'b0;
   logic [3:0] irq_ack = '0;
   logic [3:0] irq_req;
   logic [2:0] t0_ien;

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;

   always #(T_CLK/2) clk = ~clk;

   tmr16_regbank u_tmr16_regbank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .tick(tick),
      .cap_pin(cap_pin), .acmp_out(acmp_out), .cap_from_acmp(cap_from_acmp),
      .cap_on_rise(cap_on_rise), .gie(gie), .irq_ack(irq_ack),
      .irq_req(irq_req), .t0_ien(t0_ien)
   );

   // vector: {req id, is_read, addr, data/expected}
   localparam logic [18:0] VEC [NVEC] = '{
      {4'd3,  1'b0, 6'h1F, 8'h12},   // R3 stage A high
      {4'd3,  1'b0, 6'h1E, 8'h34},   // R3 commit A
      {4'd3,  1'b1, 6'h1E, 8'h34},
      {4'd4,  1'b1, 6'h1F, 8'h12},   // R4 high from staging
      {4'd3,  1'b0, 6'h1D, 8'hAB},   // R3 stage only
      {4'd3,  1'b1, 6'h1C, 8'h00},   // R3 B not yet written
      {4'd4,  1'b1, 6'h1D, 8'h00},   // R4 low read refreshed staging
      {4'd3,  1'b0, 6'h1D, 8'hAB},
      {4'd3,  1'b0, 6'h1C, 8'hCD},
      {4'd3,  1'b1, 6'h1C, 8'hCD},
      {4'd3,  1'b1, 6'h1D, 8'hAB},
      {4'd5,  1'b0, 6'h1F, 8'h77},   // R5 stage via A address
      {4'd5,  1'b0, 6'h1C, 8'h01},   // R5 commit into B
      {4'd5,  1'b1, 6'h1C, 8'h01},
      {4'd5,  1'b1, 6'h1D, 8'h77},
      {4'd5,  1'b1, 6'h1E, 8'h34},
      {4'd5,  1'b1, 6'h1F, 8'h12},
      {4'd10, 1'b0, 6'h26, 8'hFF},   // R10 mask, bit 6 reserved
      {4'd10, 1'b1, 6'h26, 8'hBF},
      {4'd10, 1'b0, 6'h26, 8'h29},
      {4'd10, 1'b1, 6'h26, 8'h29},
      {4'd3,  1'b0, 6'h1B, 8'h5A},   // R3 capture register write
      {4'd3,  1'b0, 6'h1A, 8'hA5},
      {4'd3,  1'b1, 6'h1A, 8'hA5},
      {4'd3,  1'b1, 6'h1B, 8'h5A},
      {4'd10, 1'b0, 6'h26, 8'h00},
      {4'd10, 1'b1, 6'h26, 8'h00}
   };

   task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string r);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #1;
      chk(r, {8'h00, bus_rdata}, {8'h00, exp});
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   initial begin
      #(T_CLK * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", {12'h0, irq_req}, 16'h0);
      chk("R1", {13'h0, t0_ien}, 16'h0);
      rd_chk(6'h2C, 8'h00, "R1");
      rd_chk(6'h2D, 8'h00, "R1");
      rd_chk(6'h25, 8'h00, "R1");
      rd_chk(6'h1E, 8'h00, "R1");

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][14]) rd_chk(VEC[i][13:8], VEC[i][7:0], $sformatf("R%0d", VEC[i][18:15]));
         else            wr(VEC[i][13:8], VEC[i][7:0]);
      end

      // R2 wrap and overflow flag
      wr(6'h2D, 8'hFF); wr(6'h2C, 8'hFE); wr(6'h25, 8'hFF);
      tick = 1'b1;
      repeat (2) @(negedge clk);
      tick = 1'b0;
      rd_chk(6'h2C, 8'h00, "R2");
      rd_chk(6'h2D, 8'h00, "R2");
      rd_chk(6'h25, 8'h08, "R2");

      // R12 write zero ignored, write one clears
      wr(6'h25, 8'h00); rd_chk(6'h25, 8'h08, "R12");
      wr(6'h25, 8'h08); rd_chk(6'h25, 8'h00, "R12");
      // R12 set wins over same-cycle clear
      wr(6'h2D, 8'hFF); wr(6'h2C, 8'hFE);
      tick = 1'b1;
      @(negedge clk);
      bus_addr = 6'h25; bus_wdata = 8'h08; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick = 1'b0;
      rd_chk(6'h25, 8'h08, "R12");
      wr(6'h25, 8'hFF);

      // R4 atomic read while counting across a byte boundary
      wr(6'h2D, 8'h01); wr(6'h2C, 8'hFE);
      tick = 1'b1;
      rd_chk(6'h2C, 8'hFF, "R4");
      rd_chk(6'h2D, 8'h01, "R4");
      tick = 1'b0;

      // R6 compare A then B
      wr(6'h2D, 8'h12); wr(6'h2C, 8'h32); wr(6'h25, 8'hFF);
      tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
      rd_chk(6'h25, 8'h10, "R6");
      wr(6'h2D, 8'h77); wr(6'h2C, 8'h00); wr(6'h25, 8'hFF);
      tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
      rd_chk(6'h25, 8'h20, "R6");

      // R11 gating by mask and global enable
      chk("R11", {12'h0, irq_req}, 16'h0);
      wr(6'h26, 8'h20);
      chk("R11", {12'h0, irq_req}, 16'h0);
      gie = 1'b1; #1;
      chk("R11", {12'h0, irq_req}, 16'h0004);

      // R13 acknowledge
      @(negedge clk); irq_ack = 4'b0100;
      @(negedge clk); irq_ack = 4'b0000;
      chk("R13", {12'h0, irq_req}, 16'h0);
      rd_chk(6'h25, 8'h00, "R13");

      // R7 capture latency, seen on irq_req[3]
      wr(6'h26, 8'h80); wr(6'h2D, 8'h43); wr(6'h2C, 8'h21);
      @(negedge clk); cap_pin = 1'b1;
      @(negedge clk); chk("R7", {12'h0, irq_req}, 16'h0);
      @(negedge clk); chk("R7", {12'h0, irq_req}, 16'h0);
      @(negedge clk); chk("R7", {12'h0, irq_req}, 16'h0008);
      rd_chk(6'h1A, 8'h21, "R7");
      rd_chk(6'h1B, 8'h43, "R7");

      // R8 falling polarity; rising edge ignored
      wr(6'h25, 8'hFF); cap_on_rise = 1'b0;
      wr(6'h2D, 8'h55); wr(6'h2C, 8'h55);
      cap_pin = 1'b0; repeat (4) @(negedge clk);
      rd_chk(6'h25, 8'h80, "R8");
      rd_chk(6'h1A, 8'h55, "R8");
      rd_chk(6'h1B, 8'h55, "R8");
      wr(6'h25, 8'hFF); wr(6'h2D, 8'h66); wr(6'h2C, 8'h66);
      cap_pin = 1'b1; repeat (4) @(negedge clk);
      rd_chk(6'h25, 8'h00, "R8");
      rd_chk(6'h1A, 8'h55, "R8");

      // R9 comparator source; pin ignored
      cap_on_rise = 1'b1; cap_from_acmp = 1'b1;
      repeat (4) @(negedge clk);
      wr(6'h25, 8'hFF); wr(6'h2D, 8'h0A); wr(6'h2C, 8'hBC);
      cap_pin = 1'b0; repeat (4) @(negedge clk);
      cap_pin = 1'b1; repeat (4) @(negedge clk);
      rd_chk(6'h25, 8'h00, "R9");
      acmp_out = 1'b1; repeat (4) @(negedge clk);
      rd_chk(6'h25, 8'h80, "R9");
      rd_chk(6'h1A, 8'hBC, "R9");
      rd_chk(6'h1B, 8'h0A, "R9");

      // R10 second-timer enables on t0_ien
      wr(6'h26, 8'h07);
      chk("R10", {13'h0, t0_ien}, 16'h0007);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule